// File: doc/BRIEF.md
# Half-Pixel Bus Demultiplexer

This block sits behind the pins of a narrow video input port. The sender moves each pixel as two successive 15-bit halves. The block rebuilds them into one 30-bit pixel word and carries horizontal sync, vertical sync and data enable along with that pixel. The rebuilt pixel appears on an output clock that rises once per pixel.

Two capture schemes are supported, picked by `cfgMode2x`:

- **Pixel-rate scheme:** the source clock runs at the pixel rate and both of its edges sample the bus.
- **Double-rate scheme:** the source clock runs at twice the pixel rate and only one edge samples.

The block first applies an optional clock inversion. It then applies an edge select. In the pixel-rate scheme the edge select names the edge that carries the first half. In the double-rate scheme it names the only sampling edge. The block is meant for pixel rates from 25 to 165 MHz.

All configuration inputs are quasi-static: they are changed only while reset is held. The reset is synchronous to the effective capture edge.

Top module: `halfpix_demux`

## Requirements
- R1: With `cfgMode2x`=0, `cfgInvClk`=0 and `cfgEdgeFall`=0, the half sampled at a rising `srcClk` edge is the first half of a pixel and the half sampled at the next falling edge is the second. `pixData[14:0]` holds the first half and `pixData[29:15]` holds the second.
- R2: With `cfgMode2x`=0, `cfgInvClk`=0 and `cfgEdgeFall`=1, the first half is sampled at a falling `srcClk` edge and the second half at the next rising edge. The field placement is the same as in R1.
- R3: With `cfgMode2x`=1, `cfgInvClk`=0 and `cfgEdgeFall`=0, only rising `srcClk` edges sample. Two successive samples form one pixel, the earlier one in `pixData[14:0]`.
- R4: With `cfgMode2x`=1, `cfgInvClk`=0 and `cfgEdgeFall`=1, only falling `srcClk` edges sample. Samples are paired as in R3.
- R5: `cfgInvClk`=1 inverts `srcClk` before the edge select is applied. Every edge role described for the non-inverted settings moves to the opposite `srcClk` edge.
- R6: `hsOut`, `vsOut` and `deOut` carry the values sampled together with the first half of the pixel. Sync values presented with the second half have no effect on them.
- R7: In the double-rate scheme, a sample taken with `deIn` high that follows a sample taken with `deIn` low always starts a new pixel as its first half. This holds whatever the pairing phase was before.
- R8: While `rst` is high at an effective capture edge, `pixData`, `hsOut`, `vsOut`, `deOut`, `pixValid` and the pairing phase are cleared.
- R8 (continued): After release, `pixValid` is still low at the first capture edge. It goes high at the second capture edge, when the first full pixel is loaded, and then stays high.
- R9: Each pixel is presented exactly once. The outputs only change between two rising edges of `pixClk`, never at them. In the pixel-rate scheme `pixClk` is the inverted effective capture clock; in the double-rate scheme it follows the pairing phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source clock from the sending device |
| rst | input | 1 | Synchronous reset, active high, sampled at the effective capture edge |
| cfgMode2x | input | 1 | 0: pixel-rate clock with both edges sampling; 1: double-rate clock with one sampling edge |
| cfgInvClk | input | 1 | 1: invert `srcClk` before edge selection |
| cfgEdgeFall | input | 1 | 1: the first-half edge (pixel-rate) or the sampling edge (double-rate) is the falling edge |
| dataIn | input | 15 | Half-pixel data bus |
| hsIn | input | 1 | Horizontal sync input |
| vsIn | input | 1 | Vertical sync input |
| deIn | input | 1 | Data enable input |
| pixClk | output | 1 | Output clock, one rising edge per pixel |
| pixData | output | 30 | Rebuilt pixel: first half in [14:0], second half in [29:15] |
| hsOut | output | 1 | Horizontal sync aligned with `pixData` |
| vsOut | output | 1 | Vertical sync aligned with `pixData` |
| deOut | output | 1 | Data enable aligned with `pixData` |
| pixValid | output | 1 | High once the first full pixel after reset has been loaded |

## Verification
The assertions rely on three assumptions about the inputs:

- The configuration inputs do not move outside reset.
- `deIn` has the same value in both halves of a pixel, so the double-rate pairing is only realigned at pixel boundaries.
- Every input is stable around the edge that samples it.

The stimulus respects all three. It changes data, sync and enable a quarter period after each `srcClk` edge. It changes configuration only while `rst` is asserted. It drives the same enable value in both halves of a pixel, while driving opposite sync values in the second half so that the first-half rule can be observed.

// File: rtl/halfpix_pkg.sv
package halfpix_pkg;

  // Strobes issued by the control module to the datapath.
  typedef struct packed {
    logic loadLow;   // keep the current sample as first half (double-rate)
    logic loadPix;   // move a complete pixel to the output registers
  } demux_strobe_t;

  // Timing signals travelling with each sample.
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } sync_t;

endpackage

// File: rtl/halfpix_clkfront.sv
module halfpix_clkfront (
  input  logic srcClk,
  input  logic invClk,
  input  logic edgeFall,
  input  logic mode2x,
  input  logic phase,
  output logic capClk,
  output logic pixClk
);

  logic polClk;

  // Polarity is applied first, the edge choice on top of it.
  assign polClk = srcClk ^ invClk;
  assign capClk = polClk ^ edgeFall;

  // Output clock rises halfway between two output updates.
  assign pixClk = mode2x ? phase : ~capClk;

endmodule

// File: rtl/halfpix_ctrl.sv
module halfpix_ctrl
  import halfpix_pkg::*;
(
  input  logic          capClk,
  input  logic          rst,
  input  logic          mode2x,
  input  logic          deIn,
  output demux_strobe_t strobe,
  output logic          phase,
  output logic          valid
);

  logic armed;
  logic dePrev;
  logic deRise;

  assign deRise = deIn & ~dePrev;

  always_comb begin
    strobe = '0;
    if (mode2x) begin
      strobe.loadLow = deRise | ~phase;
      strobe.loadPix = ~deRise & phase;
    end else begin
      strobe.loadPix = armed;
    end
  end

  always_ff @(posedge capClk) begin
    if (rst) begin
      phase  <= 1'b0;
      armed  <= 1'b0;
      dePrev <= 1'b0;
      valid  <= 1'b0;
    end else begin
      dePrev <= deIn;
      armed  <= 1'b1;
      valid  <= valid | strobe.loadPix;
      if (mode2x) begin
        phase <= deRise ? 1'b1 : ~phase;
      end
    end
  end

  AST_PAIR_ALTERNATE: assert property (@(posedge capClk) disable iff (rst)
    (mode2x && strobe.loadPix) |=> !strobe.loadPix); // R3

  AST_VALID_STICKY: assert property (@(posedge capClk) disable iff (rst)
    valid |=> valid); // R8

  AST_VALID_LOW_AFTER_RESET: assert property (@(posedge capClk) disable iff (rst)
    $past(rst) |-> !valid); // R8

endmodule

// File: rtl/halfpix_datapath.sv
module halfpix_datapath
  import halfpix_pkg::*;
#(
  parameter  int HALF_W = 15,
  localparam int PIX_W  = 2 * HALF_W
) (
  input  logic              capClk,
  input  logic              rst,
  input  logic              mode2x,
  input  demux_strobe_t     strobe,
  input  logic [HALF_W-1:0] dataIn,
  input  sync_t             syncIn,
  output logic [PIX_W-1:0]  pixOut,
  output sync_t             syncOut
);

  logic [HALF_W-1:0] riseData;
  logic [HALF_W-1:0] fallData;
  logic [HALF_W-1:0] lowData;
  sync_t             riseSync;
  sync_t             lowSync;
  logic [HALF_W-1:0] firstData;
  logic [HALF_W-1:0] secondData;
  sync_t             firstSync;

  always_ff @(posedge capClk) begin
    if (rst) begin
      riseData <= '0;
      riseSync <= '0;
      lowData  <= '0;
      lowSync  <= '0;
    end else begin
      riseData <= dataIn;
      riseSync <= syncIn;
      if (strobe.loadLow) begin
        lowData <= dataIn;
        lowSync <= syncIn;
      end
    end
  end

  // Second half of a pixel in the pixel-rate scheme.
  always_ff @(negedge capClk) begin
    fallData <= dataIn;
  end

  always_comb begin
    if (mode2x) begin
      firstData  = lowData;
      secondData = dataIn;
      firstSync  = lowSync;
    end else begin
      firstData  = riseData;
      secondData = fallData;
      firstSync  = riseSync;
    end
  end

  always_ff @(posedge capClk) begin
    if (rst) begin
      pixOut  <= '0;
      syncOut <= '0;
    end else if (strobe.loadPix) begin
      pixOut  <= {secondData, firstData};
      syncOut <= firstSync;
    end
  end

  AST_DE_REALIGN: assert property (@(posedge capClk) disable iff (rst)
    (mode2x && syncIn.de && !riseSync.de) |=> (lowData == $past(dataIn))); // R7

  AST_OUT_HOLD: assert property (@(posedge capClk) disable iff (rst)
    !strobe.loadPix |=> $stable(pixOut)); // R9

  AST_SYNC_HOLD: assert property (@(posedge capClk) disable iff (rst)
    !strobe.loadPix |=> $stable(syncOut)); // R6

endmodule

// File: rtl/halfpix_demux.sv
module halfpix_demux
  import halfpix_pkg::*;
#(
  parameter  int HALF_W = 15,
  localparam int PIX_W  = 2 * HALF_W
) (
  input  logic              srcClk,
  input  logic              rst,
  input  logic              cfgMode2x,
  input  logic              cfgInvClk,
  input  logic              cfgEdgeFall,
  input  logic [HALF_W-1:0] dataIn,
  input  logic              hsIn,
  input  logic              vsIn,
  input  logic              deIn,
  output logic              pixClk,
  output logic [PIX_W-1:0]  pixData,
  output logic              hsOut,
  output logic              vsOut,
  output logic              deOut,
  output logic              pixValid
);

  logic          capClk;
  logic          phase;
  demux_strobe_t strobe;
  sync_t         syncIn;
  sync_t         syncOut;

  assign syncIn = '{hs: hsIn, vs: vsIn, de: deIn};

  halfpix_clkfront u_clk (
    .srcClk   (srcClk),
    .invClk   (cfgInvClk),
    .edgeFall (cfgEdgeFall),
    .mode2x   (cfgMode2x),
    .phase    (phase),
    .capClk   (capClk),
    .pixClk   (pixClk)
  );

  halfpix_ctrl u_ctrl (
    .capClk (capClk),
    .rst    (rst),
    .mode2x (cfgMode2x),
    .deIn   (deIn),
    .strobe (strobe),
    .phase  (phase),
    .valid  (pixValid)
  );

  halfpix_datapath #(.HALF_W(HALF_W)) u_dp (
    .capClk  (capClk),
    .rst     (rst),
    .mode2x  (cfgMode2x),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .syncIn  (syncIn),
    .pixOut  (pixData),
    .syncOut (syncOut)
  );

  assign hsOut = syncOut.hs;
  assign vsOut = syncOut.vs;
  assign deOut = syncOut.de;

endmodule

// File: tb/halfpix_demux_tb.sv
module halfpix_demux_tb;

  logic        srcClk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgMode2x = 1'b0;
  logic        cfgInvClk = 1'b0;
  logic        cfgEdgeFall = 1'b0;
  logic [14:0] dataIn = '0;
  logic        hsIn = 1'b0;
  logic        vsIn = 1'b0;
  logic        deIn = 1'b0;
  logic        pixClk;
  logic [29:0] pixData;
  logic        hsOut, vsOut, deOut, pixValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [29:0] expPix [32];
  logic        expH   [32];
  logic        expV   [32];
  int          expCnt;
  logic [29:0] gotPix [32];
  logic        gotH   [32];
  logic        gotV   [32];
  int          gotCnt;
  bit          collecting = 1'b0;

  always #10 srcClk = ~srcClk;  // 50 MHz

  halfpix_demux u_dut (
    .srcClk(srcClk), .rst(rst), .cfgMode2x(cfgMode2x), .cfgInvClk(cfgInvClk),
    .cfgEdgeFall(cfgEdgeFall), .dataIn(dataIn), .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn),
    .pixClk(pixClk), .pixData(pixData), .hsOut(hsOut), .vsOut(vsOut), .deOut(deOut),
    .pixValid(pixValid)
  );

  // Sample outputs away from their update edge.
  always @(posedge pixClk) begin
    #2;
    if (collecting && pixValid && deOut && gotCnt < 32) begin
      gotPix[gotCnt] = pixData;
      gotH[gotCnt]   = hsOut;
      gotV[gotCnt]   = vsOut;
      gotCnt         = gotCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic actLvl();
    return 1'b1 ^ cfgInvClk ^ cfgEdgeFall;
  endfunction

  task automatic waitLevel(input logic lvl);
    do @(srcClk); while (srcClk !== lvl);
  endtask

  task automatic driveHalf(input logic [14:0] d, input logic h, input logic v, input logic de);
    dataIn = d; hsIn = h; vsIn = v; deIn = de;
  endtask

  task automatic sendPixel(input logic [14:0] lo, input logic [14:0] hi,
                           input logic h, input logic v, input logic de);
    if (!cfgMode2x) begin
      waitLevel(~actLvl());
      #5 driveHalf(lo, h, v, de);
      @(srcClk);
      #5 driveHalf(hi, ~h, ~v, de);
    end else begin
      waitLevel(actLvl());
      #5 driveHalf(lo, h, v, de);
      waitLevel(actLvl());
      #5 driveHalf(hi, ~h, ~v, de);
    end
  endtask

  task automatic sendIdle(input int n);
    for (int i = 0; i < n; i++) sendPixel(15'h1234, 15'h0f0f, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic sendIdleHalf();
    waitLevel(actLvl());
    #5 driveHalf(15'h1234, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic burst(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [14:0] lo, hi;
      lo = 15'(seed * 977 + i * 4099) ^ 15'h2a5;
      hi = ~lo ^ 15'(i * 7 + seed);
      if (expCnt < 32) begin
        expPix[expCnt] = {hi, lo};
        expH[expCnt]   = i[0];
        expV[expCnt]   = i[1];
        expCnt++;
      end
      sendPixel(lo, hi, i[0], i[1], 1'b1);
    end
  endtask

  task automatic applyReset(input logic m2x, input logic inv, input logic fall);
    rst = 1'b1;
    cfgMode2x = m2x; cfgInvClk = inv; cfgEdgeFall = fall;
    driveHalf(15'h1234, 1'b1, 1'b0, 1'b0);
    repeat (4) waitLevel(actLvl());
    #5 rst = 1'b0;
  endtask

  task automatic compareBurst(input string tag);
    check(gotCnt == expCnt, "R9 pixel count", 32'(gotCnt), 32'(expCnt));
    for (int i = 0; i < expCnt && i < gotCnt; i++) begin
      check(gotPix[i] == expPix[i], tag, 32'(gotPix[i]), 32'(expPix[i]));
      check({gotH[i], gotV[i]} == {expH[i], expV[i]}, "R6 sync from first half",
            32'({gotH[i], gotV[i]}), 32'({expH[i], expV[i]}));
    end
  endtask

  task automatic startCollect();
    expCnt = 0; gotCnt = 0; collecting = 1'b1;
  endtask

  task automatic stopCollect();
    repeat (12) @(posedge srcClk);
    collecting = 1'b0;
  endtask

  task automatic runCapture(input logic m2x, input logic inv, input logic fall, input string tag);
    applyReset(m2x, inv, fall);
    startCollect();
    sendIdle(2);
    burst(8, 3 + 5 * int'({m2x, inv, fall}));
    sendIdle(3);
    stopCollect();
    compareBurst(tag);
  endtask

  task automatic testReset();
    // R8: clear during reset, valid low at first edge after release
    runCapture(1'b0, 1'b0, 1'b0, "R1 pre-reset");
    rst = 1'b1;
    repeat (3) waitLevel(actLvl());
    #5;
    check(pixData == '0, "R8 pixData cleared", 32'(pixData), 32'h0);
    check({hsOut, vsOut, deOut} == 3'b000, "R8 sync cleared", 32'({hsOut, vsOut, deOut}), 32'h0);
    check(pixValid == 1'b0, "R8 valid cleared", 32'(pixValid), 32'h0);
    rst = 1'b0;
    waitLevel(actLvl());
    #5 check(pixValid == 1'b0, "R8 valid low at first edge", 32'(pixValid), 32'h0);
    waitLevel(actLvl());
    #5 check(pixValid == 1'b1, "R8 valid high at second edge", 32'(pixValid), 32'h1);
    repeat (6) waitLevel(actLvl());
    #5 check(pixValid == 1'b1, "R8 valid stays high", 32'(pixValid), 32'h1);
  endtask

  task automatic testRealign();
    // R7: odd idle gaps must not shift pairing once enable rises
    applyReset(1'b1, 1'b0, 1'b0);
    startCollect();
    for (int i = 0; i < 3; i++) sendIdleHalf();
    burst(6, 11);
    sendIdleHalf();
    burst(6, 21);
    sendIdle(3);
    stopCollect();
    compareBurst("R7 realign on enable");
  endtask

  initial begin
    repeat (150000) @(posedge srcClk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    runCapture(1'b0, 1'b0, 1'b0, "R1 pixel-rate rising first");
    runCapture(1'b0, 1'b0, 1'b1, "R2 pixel-rate falling first");
    runCapture(1'b1, 1'b0, 1'b0, "R3 double-rate rising");
    runCapture(1'b1, 1'b0, 1'b1, "R4 double-rate falling");
    runCapture(1'b0, 1'b1, 1'b0, "R5 inverted pixel-rate");
    runCapture(1'b1, 1'b1, 1'b0, "R5 inverted double-rate");
    runCapture(1'b1, 1'b1, 1'b1, "R5 inverted double-rate falling");
    testReset();
    testRealign();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule